// File: doc/BRIEF.md
# Serial EEPROM Page Transfer Controller

This block moves a configuration image between a host register bus and an external serial EEPROM, one 64-byte page per command. The EEPROM holds 164 pages of 64 bytes, a 10496-byte image, and byte j of page i lives at linear address 64*i+j. The host picks a page through a page register and streams bytes into or out of a 64-entry page buffer through a data register. It then writes a command code that starts a whole-page transfer. A single ready bit in the mode register covers both directions: it drops while a transfer runs and returns when the controller can take a new command.

On the memory side the controller drives a four-wire SPI link in mode 0: clock idle low, data sampled on the rising edge, most significant bit first. The memory's write-protect and hold inputs are assumed tied inactive high on the board. A page write is preceded by its own write-enable frame. It is followed by status polling that holds the ready bit low until the memory reports that its internal write cycle has finished. Commands that name a page past the end of the memory, or page writes while writing is disabled, are dropped without any serial activity.

Register map (2-bit address): 0 = page index (read/write, 8 bits); 1 = data port; 2 = command (write only, reads 0); 3 = mode, where bit 0 is write-enable (read/write) and bit 1 is ready (read only).

Top module: `spi_page_ctrl`

## Requirements
- R1: After reset the mode register reads 0x02 (ready=1, write-enable=0), the page register reads 0, the buffer pointer is 0, spi_cs_n is 1 and spi_sck is 0.
- R2: Each write to address 1 stores the byte at the buffer pointer and advances it. Each read of address 1 returns the byte at the pointer and advances it. The pointer wraps from 63 to 0, so 64 writes followed by 64 reads return the written bytes in order.
- R3: Writing command 0x04 returns the buffer pointer to 0. The accepted transfer commands 0x01 and 0x02 also return it to 0, so after a transfer the first data access hits buffer position 0.
- R4: Command 0x01 with write-enable set and page p at most 163 sends a one-byte chip-select frame 0x06. It then sends a frame of 0x02, the 16-bit byte address p*64 (high byte first) and the 64 buffered bytes from position 0 upward, MSB first, SPI mode 0.
- R5: After the page-write frame the controller sends repeated two-byte frames of opcode 0x05 followed by one read byte. Ready returns to 1 only after a status byte with bit 0 equal to 0 has been received.
- R6: Command 0x02 with page p at most 163 sends one frame of 0x03, the address p*64 and 64 clocked-in bytes that land in buffer positions 0 to 63, then sets ready.
- R7: Ready (mode bit 1) reads 0 from the cycle after an accepted transfer command until the transfer ends; spi_cs_n is 1 whenever ready is 1.
- R8: Writing 0x00 to the mode register clears write-enable; with write-enable clear, command 0x01 causes no chip-select activity, leaves the memory unchanged and ready stays 1.
- R9: A transfer command while the page register holds 164 or more is dropped: no chip-select activity and ready stays 1.
- R10: While ready is 0, host writes to every register are ignored and reads of the data port do not advance the pointer.
- R11: spi_sck is 0 whenever spi_cs_n is 1, and between two frames of one transfer spi_cs_n stays high for at least CS_GAP (default 4) clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host register write strobe |
| bus_rd | input | 1 | Host register read strobe (advances data pointer on address 1) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The hardest situation to reach from the ports is the status-poll loop running several times before the memory reports an idle write cycle, together with host accesses that arrive while a transfer is in flight. The bench's behavioural memory model holds its write-in-progress flag for three status reads after every program frame, so each page write must loop through four poll frames. The bench logs every frame's opcode to confirm the exact order. During a page read the bench writes the data, page and mode registers and reads the data port, then proves after completion that the page index, write-enable and buffer contents were all untouched.

// File: rtl/spi_page_pkg.sv
package spi_page_pkg;

    localparam int PAGE_BYTES = 64;
    localparam int NUM_PAGES  = 164;
    localparam int HDR_BYTES  = 3;

    // host register addresses
    localparam logic [1:0] RA_PAGE = 2'd0;
    localparam logic [1:0] RA_DATA = 2'd1;
    localparam logic [1:0] RA_CMD  = 2'd2;
    localparam logic [1:0] RA_MODE = 2'd3;

    // host command codes
    localparam logic [7:0] HC_PROG    = 8'h01;
    localparam logic [7:0] HC_LOAD    = 8'h02;
    localparam logic [7:0] HC_PTR_CLR = 8'h04;

    // memory opcodes
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_RDSR = 8'h05;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WREN,
        SQ_GAP_W,
        SQ_PROG,
        SQ_GAP_P,
        SQ_POLL,
        SQ_READ
    } seq_state_t;

    function automatic logic [15:0] page_base(input logic [7:0] pg);
        return 16'(pg) * 16'(PAGE_BYTES);
    endfunction

    // header byte n (0..2) of an addressed frame
    function automatic logic [7:0] hdr_byte(input logic [7:0] op,
                                            input logic [15:0] addr,
                                            input logic [6:0] n);
        case (n)
            7'd0:    return op;
            7'd1:    return addr[15:8];
            default: return addr[7:0];
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx,
    output logic       sck,
    output logic       mosi
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic          active;
    logic [7:0]    sh;
    logic [2:0]    bits;
    logic [DW-1:0] divc;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sh     <= '0;
            bits   <= '0;
            divc   <= '0;
            sck    <= 1'b0;
            rx     <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    sh     <= tx;
                    bits   <= '0;
                    divc   <= '0;
                    sck    <= 1'b0;
                end
            end else if (divc == DW'(DIV - 1)) begin
                divc <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                    rx  <= {rx[6:0], miso};
                end else begin
                    sck  <= 1'b0;
                    sh   <= {sh[6:0], 1'b0};
                    bits <= bits + 3'd1;
                    if (bits == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end else begin
                divc <= divc + DW'(1);
            end
        end
    end

    assign mosi = sh[7];

endmodule

// File: rtl/page_buffer.sv
module page_buffer #(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     host_we,
    input  logic                     host_adv,
    input  logic [7:0]               host_wdata,
    input  logic                     ptr_clr,
    input  logic                     eng_we,
    input  logic [$clog2(DEPTH)-1:0] eng_idx,
    input  logic [7:0]               eng_wdata,
    output logic [7:0]               host_rdata,
    output logic [7:0]               eng_rdata
);
    localparam int IW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [IW-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (ptr_clr)
            ptr <= '0;
        else if (host_adv)
            ptr <= ptr + IW'(1);
    end

    always_ff @(posedge clk) begin
        if (eng_we)
            mem[eng_idx] <= eng_wdata;
        else if (host_we)
            mem[ptr] <= host_wdata;
    end

    assign host_rdata = mem[ptr];
    assign eng_rdata  = mem[eng_idx];

endmodule

// File: rtl/spi_page_seq.sv
module spi_page_seq
    import spi_page_pkg::*;
#(
    parameter int CS_GAP = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          go_prog,
    input  logic                          go_load,
    input  logic [7:0]                    page,
    input  logic [7:0]                    buf_rdata,
    input  logic                          sh_done,
    input  logic [7:0]                    sh_rx,
    output logic                          sh_start,
    output logic [7:0]                    sh_tx,
    output logic                          buf_we,
    output logic [$clog2(PAGE_BYTES)-1:0] buf_idx,
    output logic                          cs_n,
    output logic                          ready
);
    localparam int IW        = $clog2(PAGE_BYTES);
    localparam int GW        = $clog2(CS_GAP + 1);
    localparam int PAGE_LAST = HDR_BYTES + PAGE_BYTES - 1;

    seq_state_t    st;
    logic [6:0]    cnt;
    logic          inflight;
    logic [GW-1:0] gapc;
    logic [15:0]   addr;
    logic          in_frame;
    logic [6:0]    last;

    assign addr     = page_base(page);
    assign in_frame = (st == SQ_WREN) || (st == SQ_PROG) ||
                      (st == SQ_POLL) || (st == SQ_READ);
    assign cs_n     = !in_frame;
    assign ready    = (st == SQ_IDLE);
    assign sh_start = in_frame && !inflight;
    assign buf_idx  = IW'(cnt - 7'(HDR_BYTES));
    assign buf_we   = (st == SQ_READ) && sh_done && (cnt >= 7'(HDR_BYTES));

    always_comb begin
        case (st)
            SQ_WREN: last = 7'd0;
            SQ_POLL: last = 7'd1;
            default: last = 7'(PAGE_LAST);
        endcase
    end

    always_comb begin
        case (st)
            SQ_WREN: sh_tx = OP_WREN;
            SQ_POLL: sh_tx = (cnt == 7'd0) ? OP_RDSR : 8'h00;
            SQ_PROG: sh_tx = (cnt < 7'(HDR_BYTES)) ? hdr_byte(OP_PROG, addr, cnt) : buf_rdata;
            SQ_READ: sh_tx = (cnt < 7'(HDR_BYTES)) ? hdr_byte(OP_READ, addr, cnt) : 8'h00;
            default: sh_tx = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            cnt      <= '0;
            inflight <= 1'b0;
            gapc     <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    cnt      <= '0;
                    inflight <= 1'b0;
                    if (go_prog)
                        st <= SQ_WREN;
                    else if (go_load)
                        st <= SQ_READ;
                end
                SQ_GAP_W, SQ_GAP_P: begin
                    if (gapc == GW'(CS_GAP - 1)) begin
                        gapc <= '0;
                        st   <= (st == SQ_GAP_W) ? SQ_PROG : SQ_POLL;
                    end else begin
                        gapc <= gapc + GW'(1);
                    end
                end
                default: begin
                    if (!inflight) begin
                        inflight <= 1'b1;
                    end else if (sh_done) begin
                        inflight <= 1'b0;
                        if (cnt == last) begin
                            cnt <= '0;
                            case (st)
                                SQ_WREN: st <= SQ_GAP_W;
                                SQ_PROG: st <= SQ_GAP_P;
                                SQ_POLL: st <= sh_rx[0] ? SQ_GAP_P : SQ_IDLE;
                                default: st <= SQ_IDLE;
                            endcase
                        end else begin
                            cnt <= cnt + 7'd1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_page_ctrl.sv
module spi_page_ctrl
    import spi_page_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int CS_GAP  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n
);
    localparam int IW = $clog2(PAGE_BYTES);

    logic [7:0]    page_q;
    logic          wen_q;
    logic          rdy;
    logic          wr_page, wr_data, wr_cmd, wr_mode, rd_data;
    logic          page_ok, go_prog, go_load, ptr_clr;
    logic [7:0]    host_rdata, eng_rdata, sh_tx, sh_rx;
    logic          sh_start, sh_done, buf_we;
    logic [IW-1:0] buf_idx;

    assign wr_page = bus_wr && rdy && (bus_addr == RA_PAGE);
    assign wr_data = bus_wr && rdy && (bus_addr == RA_DATA);
    assign wr_cmd  = bus_wr && rdy && (bus_addr == RA_CMD);
    assign wr_mode = bus_wr && rdy && (bus_addr == RA_MODE);
    assign rd_data = bus_rd && rdy && (bus_addr == RA_DATA);

    assign page_ok = page_q < 8'(NUM_PAGES);
    assign go_prog = wr_cmd && (bus_wdata == HC_PROG) && wen_q && page_ok;
    assign go_load = wr_cmd && (bus_wdata == HC_LOAD) && page_ok;
    assign ptr_clr = go_prog || go_load || (wr_cmd && (bus_wdata == HC_PTR_CLR));

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            wen_q  <= 1'b0;
        end else begin
            if (wr_page)
                page_q <= bus_wdata;
            if (wr_mode)
                wen_q <= bus_wdata[0];
        end
    end

    always_comb begin
        case (bus_addr)
            RA_PAGE: bus_rdata = page_q;
            RA_DATA: bus_rdata = host_rdata;
            RA_MODE: bus_rdata = {6'b0, rdy, wen_q};
            default: bus_rdata = 8'h00;
        endcase
    end

    page_buffer #(.DEPTH(PAGE_BYTES)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .host_we    (wr_data),
        .host_adv   (wr_data || rd_data),
        .host_wdata (bus_wdata),
        .ptr_clr    (ptr_clr),
        .eng_we     (buf_we),
        .eng_idx    (buf_idx),
        .eng_wdata  (sh_rx),
        .host_rdata (host_rdata),
        .eng_rdata  (eng_rdata)
    );

    spi_page_seq #(.CS_GAP(CS_GAP)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go_prog   (go_prog),
        .go_load   (go_load),
        .page      (page_q),
        .buf_rdata (eng_rdata),
        .sh_done   (sh_done),
        .sh_rx     (sh_rx),
        .sh_start  (sh_start),
        .sh_tx     (sh_tx),
        .buf_we    (buf_we),
        .buf_idx   (buf_idx),
        .cs_n      (spi_cs_n),
        .ready     (rdy)
    );

    spi_byte_shift #(.DIV(CLK_DIV)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .tx    (sh_tx),
        .miso  (spi_miso),
        .done  (sh_done),
        .rx    (sh_rx),
        .sck   (spi_sck),
        .mosi  (spi_mosi)
    );

endmodule

// File: rtl/spi_page_chk.sv
module spi_page_chk
    import spi_page_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       cs_n,
    input logic       sck,
    input logic       rdy,
    input logic [7:0] page_q,
    input logic       wen_q
);
    logic cmd_wr;
    assign cmd_wr = rdy && bus_wr && (bus_addr == RA_CMD);

    p_sck_idle_r11: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    p_ready_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        rdy |-> cs_n);

    p_load_starts_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && bus_wdata == HC_LOAD && page_q < 8'(NUM_PAGES)) |=> !rdy);

    p_bad_page_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && page_q >= 8'(NUM_PAGES)) |=> rdy);

    p_no_wen_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && bus_wdata == HC_PROG && !wen_q) |=> rdy);

    p_page_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rdy |=> $stable(page_q));

    p_wen_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rdy |=> $stable(wen_q));

endmodule

bind spi_page_ctrl spi_page_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cs_n      (spi_cs_n),
    .sck       (spi_sck),
    .rdy       (rdy),
    .page_q    (page_q),
    .wen_q     (wen_q)
);

// File: tb/test_spi_page_ctrl.sv
module test_spi_page_ctrl;

    localparam int MEM_BYTES = 10496;
    localparam int WIP_POLLS = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_mosi, spi_cs_n;
    logic       spi_miso = 1'b0;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    spi_page_ctrl i_spi_page_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n)
    );

    // ---------------- behavioural serial memory ----------------
    logic [7:0] mem_m [MEM_BYTES];
    logic [7:0] cur, opcode, out_byte;
    int         bitn, nbytes, maddr, wip_left, last_status;
    bit         wel;
    int         cs_falls = 0;
    logic [7:0] pend[$];
    int         frames[$];

    initial begin
        for (int k = 0; k < MEM_BYTES; k++) mem_m[k] = 8'hFF;
        for (int k = 0; k < 64; k++) mem_m[7*64 + k] = 8'(k) ^ 8'h5A;
        wel = 1'b0; wip_left = 0; last_status = 0;
        bitn = 0; nbytes = 0; opcode = 8'h00; out_byte = 8'h00; maddr = 0; cur = 8'h00;
    end

    always @(negedge spi_cs_n) begin
        cs_falls++;
        bitn = 0; nbytes = 0; out_byte = 8'h00;
        pend.delete();
    end

    always @(posedge spi_cs_n) begin
        if (nbytes > 0) frames.push_back(int'(opcode));
        if (opcode == 8'h02 && wel && nbytes > 3) begin
            for (int k = 0; k < pend.size(); k++) mem_m[maddr + k] = pend[k];
            wip_left = WIP_POLLS;
            wel = 1'b0;
        end
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            cur = {cur[6:0], spi_mosi};
            bitn++;
            if (bitn % 8 == 0) begin
                if (nbytes == 0) begin
                    opcode = cur;
                    if (cur == 8'h06) wel = 1'b1;
                    if (cur == 8'h05) begin
                        last_status = (wip_left > 0) ? 1 : 0;
                        out_byte = 8'(last_status);
                        if (wip_left > 0) wip_left--;
                    end
                end else if (nbytes == 1) begin
                    maddr = int'(cur) << 8;
                end else if (nbytes == 2) begin
                    maddr = maddr | int'(cur);
                    if (opcode == 8'h03) out_byte = mem_m[maddr];
                end else begin
                    if (opcode == 8'h02) pend.push_back(cur);
                    if (opcode == 8'h03) out_byte = mem_m[maddr + nbytes - 2];
                end
                nbytes++;
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) spi_miso = out_byte[7 - (bitn % 8)];
    end

    // ---------------- per-clock monitors ----------------
    int sck_bad = 0;
    int hi_run  = 0;
    int min_gap = 1000000;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (spi_cs_n && spi_sck) sck_bad++;
            if (spi_cs_n) hi_run++;
            else begin
                if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
                hi_run = 0;
            end
        end
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_ready();
        logic [7:0] m;
        m = 8'h00;
        while (m[1] == 1'b0) rd(2'd3, m);
    endtask

    task automatic check_frames(input string req, input int exp_q[$]);
        bit ok;
        ok = (frames.size() == exp_q.size());
        for (int k = 0; ok && k < exp_q.size(); k++) if (frames[k] != exp_q[k]) ok = 0;
        check(ok, req, frames.size(), exp_q.size());
    endtask

    // reference buffer model
    logic [7:0] ref_buf [64];

    initial begin
        logic [7:0] v;
        int         f0, mism;
        logic [7:0] saved;

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(2'd3, v);  check(v == 8'h02, "R1 mode after reset", v, 8'h02);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 serial idle", {spi_cs_n, spi_sck}, 2'b10);
        rd(2'd0, v);  check(v == 8'h00, "R1 page after reset", v, 0);

        // R8: write-enable readback
        wr(2'd3, 8'h01);
        rd(2'd3, v);  check(v == 8'h03, "R8 mode wen set", v, 8'h03);

        // R2: fill and drain with wrap
        for (int k = 0; k < 64; k++) begin ref_buf[k] = 8'(k * 7 + 3); wr(2'd1, ref_buf[k]); end
        mism = 0;
        for (int k = 0; k < 64; k++) begin rd(2'd1, v); if (v != ref_buf[k]) mism++; end
        check(mism == 0, "R2 buffer stream order", mism, 0);

        // R4 R5 R7: page write to page 5
        frames.delete();
        wr(2'd0, 8'd5);
        wr(2'd2, 8'h01);
        rd(2'd3, v);  check(v[1] == 1'b0, "R7 ready low during write", v, 8'h01);
        wait_ready();
        mism = 0;
        for (int k = 0; k < 64; k++) if (mem_m[5*64 + k] != ref_buf[k]) mism++;
        check(mism == 0, "R4 page 5 contents", mism, 0);
        check_frames("R4 R5 frame order", '{6, 2, 5, 5, 5, 5});
        check(last_status == 0 && wip_left == 0, "R5 ready after idle status", last_status, 0);

        // R4: last page
        for (int k = 0; k < 64; k++) begin ref_buf[k] = 8'(k) ^ 8'hC3; wr(2'd1, ref_buf[k]); end
        wr(2'd0, 8'd163);
        wr(2'd2, 8'h01);
        wait_ready();
        mism = 0;
        for (int k = 0; k < 64; k++) if (mem_m[163*64 + k] != ref_buf[k]) mism++;
        check(mism == 0, "R4 page 163 contents", mism, 0);

        // R6: page read
        frames.delete();
        wr(2'd0, 8'd7);
        wr(2'd2, 8'h02);
        rd(2'd3, v);  check(v[1] == 1'b0, "R7 ready low during read", v, 8'h01);
        wait_ready();
        check_frames("R6 single read frame", '{3});
        mism = 0;
        for (int k = 0; k < 64; k++) begin rd(2'd1, v); if (v != mem_m[7*64 + k]) mism++; end
        check(mism == 0, "R6 page 7 read data", mism, 0);

        // R3: pointer clear command
        rd(2'd1, v); rd(2'd1, v); rd(2'd1, v);
        wr(2'd2, 8'h04);
        rd(2'd1, v);  check(v == mem_m[7*64], "R3 pointer clear", v, mem_m[7*64]);

        // R3: transfer command resets pointer
        for (int k = 0; k < 5; k++) wr(2'd1, 8'hA0);
        wr(2'd0, 8'd163);
        wr(2'd2, 8'h02);
        wait_ready();
        rd(2'd1, v);  check(v == mem_m[163*64], "R3 command resets pointer", v, mem_m[163*64]);

        // R9: out-of-range page
        f0 = cs_falls;
        wr(2'd0, 8'd164);
        wr(2'd2, 8'h02);
        rd(2'd3, v);  check(v[1] == 1'b1, "R9 ready stays high (read)", v, 8'h03);
        wr(2'd2, 8'h01);
        rd(2'd3, v);  check(v[1] == 1'b1, "R9 ready stays high (write)", v, 8'h03);
        repeat (40) @(negedge clk);
        check(cs_falls == f0, "R9 no chip select", cs_falls, f0);

        // R10: host accesses while busy
        wr(2'd0, 8'd7);
        wr(2'd2, 8'h02);
        wr(2'd1, 8'hEE);
        wr(2'd0, 8'd9);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h04);
        rd(2'd1, v);
        wait_ready();
        rd(2'd0, v);  check(v == 8'd7, "R10 page unchanged", v, 7);
        rd(2'd3, v);  check(v == 8'h03, "R10 mode unchanged", v, 8'h03);
        rd(2'd1, v);  check(v == mem_m[7*64], "R10 buffer byte 0", v, mem_m[7*64]);
        rd(2'd1, v);  check(v == mem_m[7*64 + 1], "R10 buffer byte 1", v, mem_m[7*64 + 1]);

        // R8: write disabled
        wr(2'd3, 8'h00);
        rd(2'd3, v);  check(v == 8'h02, "R8 mode wen cleared", v, 8'h02);
        wr(2'd2, 8'h04);
        for (int k = 0; k < 64; k++) wr(2'd1, 8'h11);
        saved = mem_m[7*64];
        f0 = cs_falls;
        wr(2'd0, 8'd7);
        wr(2'd2, 8'h01);
        rd(2'd3, v);  check(v[1] == 1'b1, "R8 ready stays high", v, 8'h02);
        repeat (40) @(negedge clk);
        check(cs_falls == f0, "R8 no chip select", cs_falls, f0);
        check(mem_m[7*64] == saved, "R8 memory unchanged", mem_m[7*64], saved);

        // R11: serial clock discipline
        check(sck_bad == 0, "R11 sck low while deselected", sck_bad, 0);
        check(min_gap >= 4, "R11 deselect gap", min_gap, 4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule